// File: doc/BRIEF.md
# Status-Code Bus Command Decoder

This block sits between a processor running in its multiprocessor configuration and the memory bus. The processor never drives read or write strobes. At the start of every bus cycle it puts a 3-bit status code on three lines, and it returns the lines to the all-ones passive code when the cycle is over. The decoder watches those lines on every rising clock. It produces the address-latch pulse, the active-low memory command strobes, and the direction and enable controls for the data transceiver.

A cycle begins on the first clock at which the status lines are seen to leave the passive code. That clock (T1) carries a single-cycle address-latch pulse and sets the transceiver direction. On the next clock (T2), a read cycle asserts the memory-read strobe, and a write cycle asserts the early write strobe. On both kinds of cycle the transceiver enable, which is active high, turns on in T2. The normal write strobe follows one clock after the early one. Every command releases on the clock at which the passive code is seen again.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset (`rst`, active high) is held, and on the first sample after it, all three strobes are high, `ale` is low, `xcvr_en` is low and `xcvr_tx` is low.
- R2: `ale` is high for exactly one clock. It rises on the clock edge that samples a non-passive status code (passive is 3'b111) directly after a passive one. A change from one non-passive code to another non-passive code, with no passive code between them, gives no new `ale`.
- R3: Status 3'b101 is a memory read. `xcvr_tx` is low in T1. One clock after `ale`, `mem_rd_n` goes low and `xcvr_en` goes high, and both hold until release.
- R4: Status 3'b110 is a memory write. `xcvr_tx` is high from the `ale` clock onward. One clock after `ale`, `mem_wr_early_n` goes low and `xcvr_en` goes high.
- R5: In a write cycle, `mem_wr_n` goes low one clock after `mem_wr_early_n`, which is two clocks after `ale`.
- R6: The clock edge that samples the passive code drives all three strobes high, `xcvr_en` low and `xcvr_tx` low.
- R7: Any other non-passive code (3'b000 to 3'b100) gives the `ale` pulse but asserts no strobe. For such a code `xcvr_en` and `xcvr_tx` both stay low.
- R8: If the passive code comes back during T1, the cycle ends and no strobe and no enable are ever asserted for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_stat | input | 3 | Cycle status code from the processor; 3'b111 is passive |
| ale | output | 1 | Address-latch pulse, one clock long |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| mem_wr_early_n | output | 1 | Early memory write command, active low |
| xcvr_tx | output | 1 | Transceiver direction: 1 drives data out, 0 receives |
| xcvr_en | output | 1 | Transceiver enable, active high |

## Verification
A corrupted phase register shows up at the ports within one clock. Either `ale` repeats, or a strobe turns on a clock early or late compared with the `ale` pulse. A wrong stored code or previous-status value shows up in T1 or T2 as the wrong strobe, a wrong `xcvr_tx` level, or an `ale` that should not be there. The bench therefore samples every output on every clock of each cycle. It checks them against the T1/T2/T3 schedule, and it checks them again across transitions that abort a cycle or try to restart one.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
    localparam int STAT_W = 3;
    localparam logic [STAT_W-1:0] ST_PASSIVE = 3'b111;
    localparam logic [STAT_W-1:0] ST_MEM_RD  = 3'b101;
    localparam logic [STAT_W-1:0] ST_MEM_WR  = 3'b110;

    typedef enum logic [1:0] {PH_IDLE, PH_T1, PH_T2, PH_T3} phase_e;

    typedef struct packed {
        phase_e phase;
        logic   is_rd;
        logic   is_wr;
        logic   ale;
        logic   rd_n;
        logic   wr_n;
        logic   wr_early_n;
        logic   tx;
        logic   en;
    } ctl_t;
endpackage

// File: rtl/cycle_start_det.sv
module cycle_start_det
    import bus_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat,
    output logic              passive,
    output logic              start
);
    logic [STAT_W-1:0] prev_d, prev_q;

    always_comb begin
        passive = (stat == ST_PASSIVE);
        start   = (prev_q == ST_PASSIVE) && !passive;
        prev_d  = stat;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= ST_PASSIVE;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/status_classify.sv
module status_classify
    import bus_cmd_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    output logic              is_rd,
    output logic              is_wr
);
    always_comb begin
        is_rd = (stat == ST_MEM_RD);
        is_wr = (stat == ST_MEM_WR);
    end
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
    import bus_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] bus_stat,
    output logic              ale,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              mem_wr_early_n,
    output logic              xcvr_tx,
    output logic              xcvr_en
);
    logic passive, start, cls_rd, cls_wr;
    ctl_t ctl_d, ctl_q;

    cycle_start_det u_start (
        .clk     (clk),
        .rst     (rst),
        .stat    (bus_stat),
        .passive (passive),
        .start   (start)
    );

    status_classify u_cls (
        .stat  (bus_stat),
        .is_rd (cls_rd),
        .is_wr (cls_wr)
    );

    localparam ctl_t CTL_IDLE = '{phase: PH_IDLE, is_rd: 1'b0, is_wr: 1'b0,
                                  ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1,
                                  wr_early_n: 1'b1, tx: 1'b0, en: 1'b0};

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ale = 1'b0;
        case (ctl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.phase = PH_T1;
                    ctl_d.is_rd = cls_rd;
                    ctl_d.is_wr = cls_wr;
                    ctl_d.ale   = 1'b1;
                    ctl_d.tx    = cls_wr;
                end
            end
            PH_T1: begin
                if (passive) begin
                    ctl_d = CTL_IDLE;
                end else begin
                    ctl_d.phase      = PH_T2;
                    ctl_d.rd_n       = !ctl_q.is_rd;
                    ctl_d.wr_early_n = !ctl_q.is_wr;
                    ctl_d.en         = ctl_q.is_rd || ctl_q.is_wr;
                end
            end
            PH_T2: begin
                if (passive) begin
                    ctl_d = CTL_IDLE;
                end else begin
                    ctl_d.phase = PH_T3;
                    ctl_d.wr_n  = !ctl_q.is_wr;
                end
            end
            default: begin
                if (passive) ctl_d = CTL_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_IDLE;
        else     ctl_q <= ctl_d;
    end

    assign ale            = ctl_q.ale;
    assign mem_rd_n       = ctl_q.rd_n;
    assign mem_wr_n       = ctl_q.wr_n;
    assign mem_wr_early_n = ctl_q.wr_early_n;
    assign xcvr_tx        = ctl_q.tx;
    assign xcvr_en        = ctl_q.en;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (mem_rd_n && mem_wr_n && mem_wr_early_n && !ale && !xcvr_en)); // R1
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale); // R2
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_early_n)); // R3
    AST_EARLY_BEFORE_WR: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_n) |-> $past(!mem_wr_early_n)); // R5
    AST_PASSIVE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (bus_stat == ST_PASSIVE) |=> (mem_rd_n && mem_wr_n && mem_wr_early_n && !xcvr_en)); // R6
    AST_EN_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        xcvr_en |-> (!mem_rd_n || !mem_wr_early_n)); // R7
endmodule

// File: tb/sim_bus_cmd_decoder.sv
module sim_bus_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_stat = 3'b111;
    logic       ale, mem_rd_n, mem_wr_n, mem_wr_early_n, xcvr_tx, xcvr_en;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    bus_cmd_decoder u0 (
        .clk            (clk),
        .rst            (rst),
        .bus_stat       (bus_stat),
        .ale            (ale),
        .mem_rd_n       (mem_rd_n),
        .mem_wr_n       (mem_wr_n),
        .mem_wr_early_n (mem_wr_early_n),
        .xcvr_tx        (xcvr_tx),
        .xcvr_en        (xcvr_en)
    );

    // Vector order: {ale, rd_n, wr_early_n, wr_n, en, tx}
    localparam logic [5:0] V_IDLE = 6'b011100;

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {ale, mem_rd_n, mem_wr_early_n, mem_wr_n, xcvr_en, xcvr_tx};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        bus_stat = 3'b101;
        step(); chk("R1 in reset", V_IDLE);
        step(); chk("R1 in reset", V_IDLE);
        bus_stat = 3'b111;
        step();
        rst = 1'b0;
        step(); chk("R1 after reset", V_IDLE);
    endtask

    task automatic t_read();
        bus_stat = 3'b101;
        step(); chk("R2 R3 read T1", 6'b111100);
        step(); chk("R3 read T2", 6'b001110);
        step(); chk("R3 read T3", 6'b001110);
        step(); chk("R3 read hold", 6'b001110);
        bus_stat = 3'b111;
        step(); chk("R6 read release", V_IDLE);
    endtask

    task automatic t_write();
        bus_stat = 3'b110;
        step(); chk("R4 write T1", 6'b111101);
        step(); chk("R4 write T2 early", 6'b010111);
        step(); chk("R5 write T3", 6'b010011);
        step(); chk("R5 write hold", 6'b010011);
        bus_stat = 3'b111;
        step(); chk("R6 write release", V_IDLE);
    endtask

    task automatic t_other();
        bus_stat = 3'b000;
        step(); chk("R7 other T1", 6'b111100);
        step(); chk("R7 other T2", V_IDLE);
        step(); chk("R7 other T3", V_IDLE);
        bus_stat = 3'b111;
        step(); chk("R7 other end", V_IDLE);
    endtask

    task automatic t_no_restart();
        bus_stat = 3'b101;
        step(); chk("R2 first ale", 6'b111100);
        step(); chk("R3 T2", 6'b001110);
        bus_stat = 3'b110;
        step(); chk("R2 no new ale", 6'b001110);
        step(); chk("R2 code change ignored", 6'b001110);
        bus_stat = 3'b111;
        step(); chk("R6 release", V_IDLE);
    endtask

    task automatic t_abort();
        bus_stat = 3'b110;
        step(); chk("R8 abort T1", 6'b111101);
        bus_stat = 3'b111;
        step(); chk("R8 aborted", V_IDLE);
        step(); chk("R8 stays idle", V_IDLE);
    endtask

    initial begin
        t_reset();
        t_read();
        t_write();
        t_other();
        t_no_restart();
        t_abort();
        t_write();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule